// File: doc/BRIEF.md
# Bus-Master Disk DMA Control Registers

This block keeps the bus-master control state for two disk channels: for each channel a command byte, a status byte and a descriptor-table pointer. A host reaches them over a plain register bus that carries a byte offset, an access size and data. Several fields have special write rules, so the block does more than store bytes.

Setting the run bit in a command byte sends a one-cycle start pulse to that channel's DMA engine. The engine reads the channel's word-aligned descriptor pointer from a port that is valid while the pulse is high. Clearing the run bit sends an abort pulse. When the engine raises its completion strobe, the block stops the channel and latches an interrupt flag. The interrupt request output combines the interrupt flags of all channels.

Channel `c` occupies offsets `8*c` (command), `8*c+2` (status) and `8*c+4` (pointer). Address bit 3 and above select the channel.

Top module: `bmide_regfile`

## Requirements
- R1: After a synchronous reset, every status byte reads 0x60, every command byte and pointer reads 0, and `irq`, `dma_start` and `dma_abort` are low.
- R2: A byte write that changes command bit 0 (run) from 0 to 1 does three things from the next cycle on. It sets status bit 0 (active). It raises that channel's bit of `dma_start` for exactly one cycle. It presents the channel's pointer on the matching `dma_ptr` slice.
- R3: A byte write that changes the run bit from 1 to 0 clears the active bit and raises that channel's `dma_abort` bit for one cycle.
- R4: While the run bit is 1 before a write, that write cannot change command bit 3 (direction), including the write that clears run. Other command bits take the written value.
- R5: In a status write, bit 0 (active) keeps its value. Bit 1 (error) and bit 2 (interrupt) clear only where the written bit is 1, and a written 0 leaves them unchanged. Bits 7 to 3 take the written value.
- R6: A pointer write must have size word, and it stores the data with bits 1:0 forced to 0.
- R7: Sizes are coded 0 = byte, 1 = halfword, 2 = word, 3 = invalid. A write to a command or status offset that is not byte-sized, or a pointer write that is not word-sized, changes none of the command, run or pointer state. It only sets the error bit (status bit 1) of the addressed channel.
- R8: A completion strobe on `dma_done[c]` clears the run and active bits of channel `c` and sets its interrupt bit, with no abort pulse. If a host write hits the same bits in the same cycle, the strobe wins.
- R9: `irq` is high exactly when the interrupt bit of at least one channel is set.
- R10: A read returns its data on `rdata` one cycle after `rd_en`, zero-extended for command and status. Offsets 1, 3, 5, 6 and 7 inside a channel read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (4) | Byte offset |
| size | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 invalid |
| wdata | input | PTR_W (32) | Write data, right-aligned |
| rdata | output | PTR_W (32) | Registered read data |
| dma_done | input | NCH (2) | Completion strobe per channel |
| dma_start | output | NCH (2) | One-cycle start pulse per channel |
| dma_abort | output | NCH (2) | One-cycle abort pulse per channel |
| dma_ptr | output | NCH*PTR_W (64) | Descriptor pointer per channel, channel 0 in the low slice |
| irq | output | 1 | OR of the channel interrupt bits |

## Verification
The bench builds the block with its defaults: two channels and a 32-bit pointer, so the address is four bits wide. With two channels, writes, strobes and interrupt flags can be placed on one channel while the other is watched for cross-talk. It also lets `irq` be held by one channel after the other is cleared. The 32-bit pointer makes it possible to check that an all-ones write loses exactly its two low bits.

// File: rtl/bmide_pkg.sv
package bmide_pkg;
  localparam int CMD_RUN = 0;
  localparam int CMD_DIR = 3;
  localparam int STA_ACT = 0;
  localparam int STA_ERR = 1;
  localparam int STA_INT = 2;
  localparam logic [7:0] STA_INIT = 8'h60;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;
endpackage

// File: rtl/bmide_chan.sv
module bmide_chan
  import bmide_pkg::*;
#(
  parameter int PTR_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_cmd,
  input  logic             wr_sta,
  input  logic             wr_ptr,
  input  logic             bad_acc,
  input  logic [7:0]       wbyte,
  input  logic [PTR_W-1:0] wword,
  input  logic             done,
  output logic [7:0]       cmd_q,
  output logic [7:0]       sta_q,
  output logic [PTR_W-1:0] ptr_q,
  output logic             start_p,
  output logic             abort_p
);
  logic [7:0] cmd_n, sta_n;
  logic       go, stop;

  always_comb begin
    cmd_n = cmd_q;
    sta_n = sta_q;
    go    = 1'b0;
    stop  = 1'b0;
    if (wr_cmd) begin
      cmd_n = wbyte;
      if (cmd_q[CMD_RUN]) cmd_n[CMD_DIR] = cmd_q[CMD_DIR];
      go   = !cmd_q[CMD_RUN] && wbyte[CMD_RUN];
      stop = cmd_q[CMD_RUN] && !wbyte[CMD_RUN];
      if (go)   sta_n[STA_ACT] = 1'b1;
      if (stop) sta_n[STA_ACT] = 1'b0;
    end
    if (wr_sta) begin
      sta_n[7:3]     = wbyte[7:3];
      sta_n[STA_INT] = sta_q[STA_INT] & ~wbyte[STA_INT];
      sta_n[STA_ERR] = sta_q[STA_ERR] & ~wbyte[STA_ERR];
    end
    if (bad_acc) sta_n[STA_ERR] = 1'b1;
    if (done) begin
      cmd_n[CMD_RUN] = 1'b0;
      sta_n[STA_ACT] = 1'b0;
      sta_n[STA_INT] = 1'b1;
      go   = 1'b0;
      stop = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= '0;
      sta_q   <= STA_INIT;
      ptr_q   <= '0;
      start_p <= 1'b0;
      abort_p <= 1'b0;
    end else begin
      cmd_q   <= cmd_n;
      sta_q   <= sta_n;
      start_p <= go;
      abort_p <= stop;
      if (wr_ptr) ptr_q <= {wword[PTR_W-1:2], 2'b00};
    end
  end

  assert_start_sets_active_R2: assert property (@(posedge clk) disable iff (rst)
    start_p |-> (sta_q[STA_ACT] && cmd_q[CMD_RUN]));
  assert_abort_clears_active_R3: assert property (@(posedge clk) disable iff (rst)
    abort_p |-> (!sta_q[STA_ACT] && !cmd_q[CMD_RUN]));
  assert_dir_locked_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && cmd_q[CMD_RUN]) |=> (cmd_q[CMD_DIR] == $past(cmd_q[CMD_DIR])));
  assert_active_ro_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_sta && !done) |=> (sta_q[STA_ACT] == $past(sta_q[STA_ACT])));
  assert_ptr_aligned_R6: assert property (@(posedge clk) disable iff (rst)
    wr_ptr |=> (ptr_q == {$past(wword[PTR_W-1:2]), 2'b00}));
  assert_bad_size_R7: assert property (@(posedge clk) disable iff (rst)
    bad_acc |=> (sta_q[STA_ERR] && ptr_q == $past(ptr_q)));
  assert_done_stops_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> (!cmd_q[CMD_RUN] && !sta_q[STA_ACT] && sta_q[STA_INT] && !abort_p));
endmodule

// File: rtl/bmide_regfile.sv
module bmide_regfile
  import bmide_pkg::*;
#(
  parameter  int NCH    = 2,
  parameter  int PTR_W  = 32,
  localparam int SEL_W  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int ADDR_W = 3 + SEL_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [1:0]           size,
  input  logic [PTR_W-1:0]     wdata,
  output logic [PTR_W-1:0]     rdata,
  input  logic [NCH-1:0]       dma_done,
  output logic [NCH-1:0]       dma_start,
  output logic [NCH-1:0]       dma_abort,
  output logic [NCH*PTR_W-1:0] dma_ptr,
  output logic                 irq
);
  localparam logic [2:0] OFF_CMD = 3'd0;
  localparam logic [2:0] OFF_STA = 3'd2;
  localparam logic [2:0] OFF_PTR = 3'd4;

  logic [7:0]       cmd_a [NCH];
  logic [7:0]       sta_a [NCH];
  logic [PTR_W-1:0] ptr_a [NCH];
  logic [NCH-1:0]   int_v;
  logic [2:0]       off;
  logic [SEL_W-1:0] sel;
  logic             byte_ok, word_ok;

  assign off     = addr[2:0];
  assign sel     = addr[ADDR_W-1:3];
  assign byte_ok = (size == SZ_BYTE);
  assign word_ok = (size == SZ_WORD);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit, w_cmd, w_sta, w_ptr, bad;
    assign hit   = wr_en && (sel == SEL_W'(c));
    assign w_cmd = hit && (off == OFF_CMD) && byte_ok;
    assign w_sta = hit && (off == OFF_STA) && byte_ok;
    assign w_ptr = hit && (off == OFF_PTR) && word_ok;
    assign bad   = hit && ((((off == OFF_CMD) || (off == OFF_STA)) && !byte_ok) ||
                           ((off == OFF_PTR) && !word_ok));

    bmide_chan #(.PTR_W(PTR_W)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .wr_cmd  (w_cmd),
      .wr_sta  (w_sta),
      .wr_ptr  (w_ptr),
      .bad_acc (bad),
      .wbyte   (wdata[7:0]),
      .wword   (wdata),
      .done    (dma_done[c]),
      .cmd_q   (cmd_a[c]),
      .sta_q   (sta_a[c]),
      .ptr_q   (ptr_a[c]),
      .start_p (dma_start[c]),
      .abort_p (dma_abort[c])
    );

    assign dma_ptr[c*PTR_W +: PTR_W] = ptr_a[c];
    assign int_v[c] = sta_a[c][STA_INT];
  end

  assign irq = |int_v;

  logic [PTR_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NCH; c++) begin
      if (sel == SEL_W'(c)) begin
        case (off)
          OFF_CMD: rd_mux = PTR_W'(cmd_a[c]);
          OFF_STA: rd_mux = PTR_W'(sta_a[c]);
          OFF_PTR: rd_mux = ptr_a[c];
          default: rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  assert_irq_follows_ch0_R9: assert property (@(posedge clk) disable iff (rst)
    dma_done[0] |=> irq);
  assert_pulse_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    (dma_start & dma_abort) == '0);
endmodule

// File: tb/tb_bmide_regfile.sv
`timescale 1ns/1ps
module tb_bmide_regfile;
  localparam int NCH = 2;
  localparam int PTR_W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [1:0] size = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0] dma_done = '0, dma_start, dma_abort;
  logic [63:0] dma_ptr;
  logic irq;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bmide_regfile #(.NCH(NCH), .PTR_W(PTR_W)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .size(size), .wdata(wdata), .rdata(rdata), .dma_done(dma_done),
    .dma_start(dma_start), .dma_abort(dma_abort), .dma_ptr(dma_ptr), .irq(irq)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [1:0] s, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; size = s; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(string req, logic [3:0] a, logic [31:0] exp);
    @(negedge clk);
    rd_en = 1'b1; addr = a; size = 2'd0;
    @(negedge clk);
    rd_en = 1'b0;
    check(req, 64'(rdata), 64'(exp));
  endtask

  task automatic done_pulse(int c);
    @(negedge clk);
    dma_done[c] = 1'b1;
    @(negedge clk);
    dma_done = '0;
    check("R8 no abort on completion", 64'(dma_abort), 64'd0);
  endtask

  task automatic t_reset;
    check("R1 irq", 64'(irq), 64'd0);
    check("R1 start", 64'(dma_start), 64'd0);
    check("R1 abort", 64'(dma_abort), 64'd0);
    rd("R1 sta0", 4'h2, 32'h60);
    rd("R1 sta1", 4'hA, 32'h60);
    rd("R1 cmd0", 4'h0, 32'h0);
    rd("R1 ptr1", 4'hC, 32'h0);
  endtask

  task automatic t_start_abort;
    wr(4'h4, 2'd2, 32'h1234_5677);
    rd("R6 ptr0 aligned", 4'h4, 32'h1234_5674);
    wr(4'h0, 2'd0, 32'h09);
    check("R2 start pulse", 64'(dma_start), 64'h1);
    check("R2 ptr out", 64'(dma_ptr[31:0]), 64'h1234_5674);
    @(negedge clk);
    check("R2 pulse one cycle", 64'(dma_start), 64'h0);
    rd("R2 active", 4'h2, 32'h61);
    rd("R2 ch1 untouched", 4'hA, 32'h60);
    wr(4'h0, 2'd0, 32'h01);
    check("R2 no repeat start", 64'(dma_start), 64'h0);
    rd("R4 dir locked", 4'h0, 32'h09);
    wr(4'h2, 2'd0, 32'h60);
    rd("R5 active read-only", 4'h2, 32'h61);
    wr(4'h0, 2'd0, 32'h00);
    check("R3 abort pulse", 64'(dma_abort), 64'h1);
    rd("R3 active cleared", 4'h2, 32'h60);
    rd("R4 dir kept on stop", 4'h0, 32'h08);
    wr(4'h0, 2'd0, 32'h00);
    rd("R4 dir free when idle", 4'h0, 32'h00);
  endtask

  task automatic t_done_irq;
    wr(4'hC, 2'd2, 32'hFFFF_FFFF);
    rd("R6 ptr1 all ones", 4'hC, 32'hFFFF_FFFC);
    wr(4'h8, 2'd0, 32'h01);
    check("R2 ch1 start", 64'(dma_start), 64'h2);
    check("R2 ch1 ptr", 64'(dma_ptr[63:32]), 64'hFFFF_FFFC);
    done_pulse(1);
    check("R9 irq set", 64'(irq), 64'd1);
    rd("R8 run cleared", 4'h8, 32'h00);
    rd("R8 status", 4'hA, 32'h64);
    wr(4'hA, 2'd0, 32'h60);
    rd("R5 zero keeps int", 4'hA, 32'h64);
    wr(4'h0, 2'd0, 32'h01);
    done_pulse(0);
    wr(4'hA, 2'd0, 32'h64);
    rd("R5 W1C int", 4'hA, 32'h60);
    check("R9 irq held by ch0", 64'(irq), 64'd1);
    wr(4'h2, 2'd0, 32'h64);
    check("R9 irq cleared", 64'(irq), 64'd0);
  endtask

  task automatic t_size_err;
    wr(4'h0, 2'd2, 32'h01);
    check("R7 no start on bad size", 64'(dma_start), 64'h0);
    rd("R7 cmd unchanged", 4'h0, 32'h00);
    rd("R7 err set", 4'h2, 32'h62);
    wr(4'h4, 2'd0, 32'hAB);
    rd("R7 ptr unchanged", 4'h4, 32'h1234_5674);
    wr(4'hA, 2'd3, 32'h04);
    rd("R7 ch1 err", 4'hA, 32'h62);
    wr(4'h2, 2'd0, 32'h60);
    rd("R5 zero keeps err", 4'h2, 32'h62);
    wr(4'h2, 2'd0, 32'h02);
    rd("R5 W1C err and plain bits", 4'h2, 32'h00);
  endtask

  task automatic t_unmapped;
    wr(4'h6, 2'd0, 32'hFF);
    wr(4'h1, 2'd0, 32'hFF);
    rd("R10 off6 zero", 4'h6, 32'h0);
    rd("R10 off1 zero", 4'h1, 32'h0);
    rd("R10 cmd untouched", 4'h0, 32'h0);
    check("R10 no pulse", 64'({dma_start, dma_abort}), 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_start_abort();
    t_done_irq();
    t_size_err();
    t_unmapped();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule